// File: doc/BRIEF.md
# USB Endpoint Handshake Responder

This block sits beside a USB device's serial interface engine and decides how each incoming token is answered. It keeps one small control register per endpoint number. The register says whether the number acts as a control endpoint, an IN endpoint, an OUT endpoint or an IN/OUT pair, whether it is halted, and whether handshakes are suppressed for isochronous traffic. When a token arrives, the block combines that register with the ownership flag of the selected buffer descriptor and with the receive-status flag. It then names the answer to send: acknowledge, negative acknowledge, stall, no handshake, or silence (the token is ignored).

Alongside the answer, a one-cycle strobe tells the descriptor engine to move data, either to take the received payload or to send the prepared one. Packet framing, CRC and data toggling are handled elsewhere. Control registers are loaded through a simple write port. An accepted SETUP token also clears the halt flag of its endpoint.

Top module: `usb_ep_responder`

## Requirements
- R1: After reset every endpoint control register is zero, so every endpoint is disabled, and `rsp_valid` and `xfer_go` are 0.
- R2: A token presented with `tok_valid`=1 gets its answer on `rsp_valid`/`rsp_code`/`xfer_go` exactly one clock later. Token codes on `tok_type` are 2'b01 OUT, 2'b10 IN, 2'b11 SETUP and 2'b00 reserved (always ignored). Answer codes on `rsp_code` are 0 ignore, 1 ACK, 2 NAK, 3 STALL and 4 no handshake.
- R3: Control register bits are [0] control, [1] IN enable, [2] OUT enable, [3] stall, [4] handshake disable. An IN token is allowed when bit 0 or bit 1 is set, and an OUT token when bit 0 or bit 2 is set, so setting both bits 1 and 2 gives a pair. A token for a direction that is not allowed is answered with code 0 and `xfer_go`=0, whatever the stall and ownership state.
- R4: On an allowed IN or OUT token with the stall bit set, the answer is STALL and `xfer_go` is 0, whatever the ownership.
- R5: On an allowed token that is not stalled and has `desc_own`=0, the answer is NAK and `xfer_go` is 0. This covers IN, OUT and SETUP.
- R6: An allowed, unstalled OUT token with `desc_own`=1 answers ACK with `xfer_go`=1 when `rx_ok`=1. When `rx_ok`=0 it answers no handshake with `xfer_go`=0.
- R7: An allowed, unstalled IN token with `desc_own`=1 gives `xfer_go`=1 and the code no handshake, because the device sends data and the host acknowledges it.
- R8: A SETUP token is allowed only when bit 0 is set. It ignores the stall bit and otherwise answers like an OUT token. Any SETUP to a control endpoint clears that endpoint's stall bit at the same edge.
- R9: With the handshake-disable bit set, any answer that would be ACK, NAK or STALL becomes no handshake, and `xfer_go` stays as it would otherwise be.
- R10: A control write takes effect at the clock edge, so a token in the same cycle is judged on the old value. When a write and a stall-clearing SETUP hit the same endpoint in the same cycle, the written value is kept.
- R11: In any cycle after one with `tok_valid`=0, `rsp_valid` and `xfer_go` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_ep | input | EP_W (4) | Endpoint number written |
| cfg_data | input | 5 | Control value: [0] control, [1] IN, [2] OUT, [3] stall, [4] handshake disable |
| tok_valid | input | 1 | Token present this cycle |
| tok_type | input | 2 | 01 OUT, 10 IN, 11 SETUP, 00 reserved |
| tok_ep | input | EP_W (4) | Endpoint number of the token |
| desc_own | input | 1 | Engine owns the selected descriptor |
| rx_ok | input | 1 | Received data packet was good |
| rsp_valid | output | 1 | Answer present |
| rsp_code | output | 3 | 0 ignore, 1 ACK, 2 NAK, 3 STALL, 4 no handshake |
| xfer_go | output | 1 | Strobe to the descriptor engine to move data |

## Verification
Two functions can meet in one clock: a control write and a token decision on the same endpoint, and a control write and the stall clear caused by a SETUP. The bench drives a write and a token to the same endpoint in one cycle and checks that the answer follows the old register value while the next token follows the new one. It also writes a stalled control value in the same cycle as a SETUP to that endpoint, then sends an IN token and expects STALL, which shows that the write won over the clear.

// File: rtl/usb_ep_pkg.sv
package usb_ep_pkg;

   typedef enum logic [1:0] {
      TOK_RSVD  = 2'b00,
      TOK_OUT   = 2'b01,
      TOK_IN    = 2'b10,
      TOK_SETUP = 2'b11
   } tok_e;

   typedef enum logic [2:0] {
      RSP_IGNORE = 3'd0,
      RSP_ACK    = 3'd1,
      RSP_NAK    = 3'd2,
      RSP_STALL  = 3'd3,
      RSP_NOHS   = 3'd4
   } rsp_e;

   // packed so that bit 0 is the control-endpoint flag
   typedef struct packed {
      logic no_hs;
      logic stall;
      logic out_en;
      logic in_en;
      logic ctl;
   } ep_cfg_t;

   localparam int CFG_W = $bits(ep_cfg_t);

endpackage

// File: rtl/ep_ctrl_bank.sv
module ep_ctrl_bank
   import usb_ep_pkg::*;
#(
   parameter int NUM_EP = 16,
   localparam int EP_W = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [EP_W-1:0] wr_ep,
   input  ep_cfg_t         wr_val,
   input  logic            clr_en,
   input  logic [EP_W-1:0] clr_ep,
   input  logic [EP_W-1:0] rd_ep,
   output ep_cfg_t         rd_val
);

   ep_cfg_t regs [NUM_EP];

   for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
      logic hit_wr;
      logic hit_clr;
      assign hit_wr  = wr_en  && (wr_ep  == EP_W'(i));
      assign hit_clr = clr_en && (clr_ep == EP_W'(i));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            regs[i] <= '0;
         end else if (hit_wr) begin
            regs[i] <= wr_val;
         end else if (hit_clr) begin
            regs[i].stall <= 1'b0;
         end
      end
   end

   assign rd_val = regs[rd_ep];

endmodule

// File: rtl/ep_resp_decide.sv
module ep_resp_decide
   import usb_ep_pkg::*;
(
   input  logic    tok_valid,
   input  tok_e    tok_type,
   input  ep_cfg_t cfg,
   input  logic    own,
   input  logic    rx_ok,
   output rsp_e    rsp,
   output logic    go,
   output logic    clr_stall
);

   logic dir_ok;
   logic is_setup;
   rsp_e raw;

   assign is_setup = (tok_type == TOK_SETUP);

   always_comb begin
      unique case (tok_type)
         TOK_OUT:   dir_ok = cfg.ctl | cfg.out_en;
         TOK_IN:    dir_ok = cfg.ctl | cfg.in_en;
         TOK_SETUP: dir_ok = cfg.ctl;
         default:   dir_ok = 1'b0;
      endcase
   end

   // priority: direction, stall, ownership, normal answer
   always_comb begin
      raw = RSP_IGNORE;
      go  = 1'b0;
      if (tok_valid && dir_ok) begin
         if (!is_setup && cfg.stall) begin
            raw = RSP_STALL;
         end else if (!own) begin
            raw = RSP_NAK;
         end else if (tok_type == TOK_IN) begin
            raw = RSP_NOHS;
            go  = 1'b1;
         end else if (rx_ok) begin
            raw = RSP_ACK;
            go  = 1'b1;
         end else begin
            raw = RSP_NOHS;
         end
      end
   end

   always_comb begin
      rsp = raw;
      if (cfg.no_hs && (raw == RSP_ACK || raw == RSP_NAK || raw == RSP_STALL)) begin
         rsp = RSP_NOHS;
      end
   end

   assign clr_stall = tok_valid && is_setup && cfg.ctl;

endmodule

// File: rtl/usb_ep_responder.sv
module usb_ep_responder
   import usb_ep_pkg::*;
#(
   parameter int NUM_EP  = 16,
   parameter bit REG_OUT = 1'b1,
   localparam int EP_W = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cfg_we,
   input  logic [EP_W-1:0] cfg_ep,
   input  logic [4:0]      cfg_data,
   input  logic            tok_valid,
   input  logic [1:0]      tok_type,
   input  logic [EP_W-1:0] tok_ep,
   input  logic            desc_own,
   input  logic            rx_ok,
   output logic            rsp_valid,
   output logic [2:0]      rsp_code,
   output logic            xfer_go
);

   if (NUM_EP < 2 || NUM_EP > 16) begin : g_bad_count
      $error("NUM_EP must lie in 2..16");
   end
   if ((1 << EP_W) != NUM_EP) begin : g_bad_pow2
      $error("NUM_EP must be a power of two");
   end
   if (CFG_W != 5) begin : g_bad_cfg
      $error("control word width mismatch");
   end

   ep_cfg_t sel_cfg;
   rsp_e    d_rsp;
   logic    d_go;
   logic    d_clr;

   ep_ctrl_bank #(.NUM_EP(NUM_EP)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (cfg_we),
      .wr_ep  (cfg_ep),
      .wr_val (ep_cfg_t'(cfg_data)),
      .clr_en (d_clr),
      .clr_ep (tok_ep),
      .rd_ep  (tok_ep),
      .rd_val (sel_cfg)
   );

   ep_resp_decide u_dec (
      .tok_valid (tok_valid),
      .tok_type  (tok_e'(tok_type)),
      .cfg       (sel_cfg),
      .own       (desc_own),
      .rx_ok     (rx_ok),
      .rsp       (d_rsp),
      .go        (d_go),
      .clr_stall (d_clr)
   );

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_code  <= RSP_IGNORE;
            xfer_go   <= 1'b0;
         end else begin
            rsp_valid <= tok_valid;
            rsp_code  <= d_rsp;
            xfer_go   <= d_go;
         end
      end
   end else begin : g_comb
      assign rsp_valid = tok_valid;
      assign rsp_code  = d_rsp;
      assign xfer_go   = d_go;
   end

endmodule

// File: rtl/usb_ep_responder_chk.sv
module usb_ep_responder_chk #(
   parameter int EP_W    = 4,
   parameter bit REG_OUT = 1'b1
) (
   input logic       clk,
   input logic       rst_n,
   input logic       tok_valid,
   input logic [1:0] tok_type,
   input logic       desc_own,
   input logic       rx_ok,
   input logic       rsp_valid,
   input logic [2:0] rsp_code,
   input logic       xfer_go
);

   if (REG_OUT) begin : g_props
      // R2 R11
      resp_follows_token_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !tok_valid |=> (!rsp_valid && !xfer_go));

      // R6 R7 R9
      go_only_with_pass_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
         xfer_go |-> (rsp_valid && (rsp_code == 3'd1 || rsp_code == 3'd4)));

      // R3 R4 R5
      refusal_moves_nothing_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (rsp_code == 3'd0 || rsp_code == 3'd2 || rsp_code == 3'd3) |-> !xfer_go);

      // R5
      unowned_no_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (tok_valid && !desc_own) |=> !xfer_go);

      // R6
      bad_out_data_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (tok_valid && tok_type == 2'b01 && !rx_ok) |=> !xfer_go);

      // R2
      code_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
         rsp_valid |-> (rsp_code <= 3'd4));
   end

endmodule

bind usb_ep_responder usb_ep_responder_chk #(.EP_W(EP_W), .REG_OUT(REG_OUT)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tok_valid (tok_valid),
   .tok_type  (tok_type),
   .desc_own  (desc_own),
   .rx_ok     (rx_ok),
   .rsp_valid (rsp_valid),
   .rsp_code  (rsp_code),
   .xfer_go   (xfer_go)
);

// File: tb/sim_usb_ep_responder.sv
`timescale 1ns/1ps
module sim_usb_ep_responder;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_we = 1'b0;
   logic [3:0] cfg_ep = '0;
   logic [4:0] cfg_data = '0;
   logic       tok_valid = 1'b0;
   logic [1:0] tok_type = '0;
   logic [3:0] tok_ep = '0;
   logic       desc_own = 1'b0;
   logic       rx_ok = 1'b0;
   logic       rsp_valid;
   logic [2:0] rsp_code;
   logic       xfer_go;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   usb_ep_responder u0 (.*);

   // {cfg[4:0], type[1:0], own, rx_ok, code[2:0], go}
   localparam int NV = 19;
   localparam logic [12:0] VEC [NV] = '{
      {5'b00010, 2'b10, 1'b1, 1'b1, 3'd4, 1'b1},  // R7 IN owned
      {5'b00010, 2'b10, 1'b0, 1'b1, 3'd2, 1'b0},  // R5 IN unowned
      {5'b00010, 2'b01, 1'b1, 1'b1, 3'd0, 1'b0},  // R3 OUT on IN-only
      {5'b00100, 2'b01, 1'b1, 1'b1, 3'd1, 1'b1},  // R6 OUT good
      {5'b00100, 2'b01, 1'b1, 1'b0, 3'd4, 1'b0},  // R6 OUT bad data
      {5'b00100, 2'b10, 1'b1, 1'b1, 3'd0, 1'b0},  // R3 IN on OUT-only
      {5'b00110, 2'b10, 1'b1, 1'b1, 3'd4, 1'b1},  // R3 pair IN
      {5'b00110, 2'b01, 1'b0, 1'b1, 3'd2, 1'b0},  // R5 pair OUT unowned
      {5'b01110, 2'b10, 1'b1, 1'b1, 3'd3, 1'b0},  // R4 stall IN
      {5'b01100, 2'b01, 1'b0, 1'b1, 3'd3, 1'b0},  // R4 stall beats ownership
      {5'b01010, 2'b01, 1'b1, 1'b1, 3'd0, 1'b0},  // R3 disabled beats stall
      {5'b00001, 2'b11, 1'b1, 1'b1, 3'd1, 1'b1},  // R8 SETUP good
      {5'b00110, 2'b11, 1'b1, 1'b1, 3'd0, 1'b0},  // R8 SETUP non-control
      {5'b00001, 2'b10, 1'b1, 1'b1, 3'd4, 1'b1},  // R3 control allows IN
      {5'b10100, 2'b01, 1'b1, 1'b1, 3'd4, 1'b1},  // R9 ACK hidden
      {5'b11100, 2'b01, 1'b1, 1'b1, 3'd4, 1'b0},  // R9 STALL hidden
      {5'b10010, 2'b10, 1'b0, 1'b1, 3'd4, 1'b0},  // R9 NAK hidden
      {5'b00111, 2'b00, 1'b1, 1'b1, 3'd0, 1'b0},  // R2 reserved token
      {5'b01001, 2'b11, 1'b0, 1'b1, 3'd2, 1'b0}   // R5 SETUP unowned
   };

   task automatic check(string req, logic [2:0] code, logic go);
      checks++;
      if (rsp_valid !== 1'b1 || rsp_code !== code || xfer_go !== go) begin
         fails++;
         $display("FAIL %s: valid=%b code=%0d go=%b expected valid=1 code=%0d go=%b",
                  req, rsp_valid, rsp_code, xfer_go, code, go);
      end
   endtask

   task automatic wcfg(logic [3:0] ep, logic [4:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_ep = ep; cfg_data = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   // token and optional same-cycle write; answer sampled one edge later
   task automatic tok(logic [1:0] t, logic [3:0] ep, logic own, logic ok,
                      logic we, logic [4:0] d);
      @(negedge clk);
      tok_valid = 1'b1; tok_type = t; tok_ep = ep; desc_own = own; rx_ok = ok;
      cfg_we = we; cfg_ep = ep; cfg_data = d;
      @(negedge clk);
      tok_valid = 1'b0; cfg_we = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 outputs idle in reset
      checks++;
      if (rsp_valid !== 1'b0 || xfer_go !== 1'b0) begin
         fails++;
         $display("FAIL R1: valid=%b go=%b expected 0 0", rsp_valid, xfer_go);
      end
      rst_n = 1'b1;

      // R1 endpoints disabled after reset
      tok(2'b10, 4'd0, 1'b1, 1'b1, 1'b0, '0);
      check("R1", 3'd0, 1'b0);
      tok(2'b01, 4'd9, 1'b1, 1'b1, 1'b0, '0);
      check("R1", 3'd0, 1'b0);

      for (int i = 0; i < NV; i++) begin
         wcfg(4'd3, VEC[i][12:8]);
         tok(VEC[i][7:6], 4'd3, VEC[i][5], VEC[i][4], 1'b0, '0);
         check($sformatf("R2 vector %0d", i), VEC[i][3:1], VEC[i][0]);
      end

      // R11 idle cycle gives no answer
      @(negedge clk);
      checks++;
      if (rsp_valid !== 1'b0 || xfer_go !== 1'b0) begin
         fails++;
         $display("FAIL R11: valid=%b go=%b expected 0 0", rsp_valid, xfer_go);
      end

      // R8 SETUP clears stall
      wcfg(4'd5, 5'b01001);
      tok(2'b10, 4'd5, 1'b1, 1'b1, 1'b0, '0);
      check("R8 stalled before SETUP", 3'd3, 1'b0);
      tok(2'b11, 4'd5, 1'b1, 1'b1, 1'b0, '0);
      check("R8 SETUP on stalled", 3'd1, 1'b1);
      tok(2'b10, 4'd5, 1'b1, 1'b1, 1'b0, '0);
      check("R8 stall cleared", 3'd4, 1'b1);

      // R10 write beats SETUP clear in same cycle
      tok(2'b11, 4'd5, 1'b1, 1'b1, 1'b1, 5'b01001);
      check("R10 SETUP with write", 3'd1, 1'b1);
      tok(2'b10, 4'd5, 1'b1, 1'b1, 1'b0, '0);
      check("R10 written stall kept", 3'd3, 1'b0);

      // R10 token in write cycle uses old value
      tok(2'b10, 4'd6, 1'b1, 1'b1, 1'b1, 5'b00010);
      check("R10 old value", 3'd0, 1'b0);
      tok(2'b10, 4'd6, 1'b1, 1'b1, 1'b0, '0);
      check("R10 new value", 3'd4, 1'b1);

      // R3 other endpoints untouched
      tok(2'b10, 4'd7, 1'b1, 1'b1, 1'b0, '0);
      check("R3 neighbour disabled", 3'd0, 1'b0);

      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (5000) @(posedge clk);
            checks++;
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
         end
      join_any
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule